// File: doc/BRIEF.md
# Flexible Second-Operand Generator

This block forms the second ALU operand of a 32-bit load/store datapath, together with the carry that the shifter produces. In immediate mode it expands a short constant encoding into a full word. The encoding is either one byte placed at any left offset, or one byte repeated into a fixed set of byte lanes. In register mode it passes a register value through a logical, arithmetic or rotating shift, or through a one-bit rotation that includes the carry flag.

The block has no state. Both outputs follow the inputs within the same cycle. Decode logic selects the mode and supplies the fields. The register file supplies the value. The ALU consumes the operand, and it consumes the shifter carry for logical instructions that update the flags.

Top module: `flex_operand_gen`

## Requirements
- R1: When `use_imm`=1 and `imm_form`=0, `operand` equals `imm_byte` shifted left by `imm_offset` (0..31). Bits moved past bit 31 are lost.
- R2: When `use_imm`=1 and `imm_form`=1, `operand` is the byte in bits 23:16 and 7:0, with zeros elsewhere. `imm_offset` has no effect.
- R3: When `use_imm`=1, `imm_form`=2 gives the byte in bits 31:24 and 15:8, and `imm_form`=3 gives the byte in all four lanes. `imm_offset` has no effect in either case.
- R4: When `use_imm`=1, `carry_out` equals `carry_in`, and the register-side inputs do not affect either output.
- R5: `sh_kind`=0 is a logical left shift. For an amount n in 1..31, vacated low bits are zero and `carry_out` is `reg_val[32-n]`.
- R6: `sh_kind`=1 is a logical right shift. For n in 1..31, vacated high bits are zero and `carry_out` is `reg_val[n-1]`.
- R7: `sh_kind`=2 is an arithmetic right shift. For n in 1..31, vacated high bits copy `reg_val[31]` and `carry_out` is `reg_val[n-1]`.
- R8: `sh_kind`=3 is a right rotation. For n in 1..31, `carry_out` is `reg_val[n-1]`, which is also the new bit 31.
- R9: For `sh_kind` 0..3 with `sh_amount`=0, `operand` equals `reg_val` and `carry_out` equals `carry_in`.
- R10: `sh_kind`=4 rotates right by one bit through the carry. `operand` is {`carry_in`, `reg_val[31:1]`}, `carry_out` is `reg_val[0]`, and `sh_amount` has no effect.
- R11: The unused codes `sh_kind`=5..7 give `operand`=`reg_val` and `carry_out`=`carry_in`.
- R12: The block is combinational: a change at the inputs reaches both outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | 1 selects the immediate expander, 0 selects the register shifter |
| imm_byte | input | 8 | Byte value of the immediate |
| imm_form | input | 2 | 0 placed byte, 1 even lanes, 2 odd lanes, 3 all lanes |
| imm_offset | input | 5 | Left offset for the placed-byte form |
| reg_val | input | 32 | Register value to be shifted |
| sh_kind | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry, 5..7 pass |
| sh_amount | input | 5 | Shift distance |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Generated second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The assertions assume that every input holds a defined value. They also assume that the shift distance cannot reach 32, which the 5-bit field guarantees, so no check covers a shift of the full width. The stimulus drives only defined values, covers every `sh_kind` code including the unused ones, and sets the amount to 0, 1 and 31 as well as to random values. Inputs change only on the falling clock edge, so the outputs have settled by the time the properties and the comparisons sample them.

// File: rtl/opgen_pkg.sv
package opgen_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int SHAMT_W = $clog2(WORD_W);

    typedef enum logic [2:0] {
        SHK_LSL  = 3'd0,
        SHK_LSR  = 3'd1,
        SHK_ASR  = 3'd2,
        SHK_ROR  = 3'd3,
        SHK_RRX  = 3'd4,
        SHK_RSV5 = 3'd5,
        SHK_RSV6 = 3'd6,
        SHK_RSV7 = 3'd7
    } shift_kind_e;

    typedef enum logic [1:0] {
        IMF_PLACED = 2'd0,
        IMF_EVEN   = 2'd1,
        IMF_ODD    = 2'd2,
        IMF_ALL    = 2'd3
    } imm_form_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              carry;
    } operand_t;

endpackage

// File: rtl/opgen_imm_expand.sv
module opgen_imm_expand
    import opgen_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int BW    = BYTE_W
) (
    input  logic [BW-1:0]            value,
    input  imm_form_e                form,
    input  logic [$clog2(WIDTH)-1:0] offset,
    output logic [WIDTH-1:0]         word
);
    localparam int LANES = WIDTH / BW;

    logic [WIDTH-1:0] placed;
    logic [WIDTH-1:0] replicated;
    logic             even_on;
    logic             odd_on;

    assign placed  = {{(WIDTH-BW){1'b0}}, value} << offset;
    assign even_on = (form == IMF_EVEN) || (form == IMF_ALL);
    assign odd_on  = (form == IMF_ODD)  || (form == IMF_ALL);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        if (ln % 2 == 0) begin : g_even
            assign replicated[ln*BW +: BW] = even_on ? value : '0;
        end else begin : g_odd
            assign replicated[ln*BW +: BW] = odd_on ? value : '0;
        end
    end

    assign word = (form == IMF_PLACED) ? placed : replicated;

endmodule

// File: rtl/opgen_shifter.sv
module opgen_shifter
    import opgen_pkg::*;
#(
    parameter int WIDTH = WORD_W
) (
    input  logic [WIDTH-1:0]         value,
    input  shift_kind_e              kind,
    input  logic [$clog2(WIDTH)-1:0] amount,
    input  logic                     carry_in,
    output logic [WIDTH-1:0]         result,
    output logic                     carry_out
);
    localparam int SHW = $clog2(WIDTH);
    localparam int EXT = 2 * WIDTH + 1;

    function automatic logic [WIDTH-1:0] flip(input logic [WIDTH-1:0] v);
        logic [WIDTH-1:0] r;
        for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
        return r;
    endfunction

    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] fill;
    logic [EXT-1:0]   stage [SHW+1];
    logic [WIDTH-1:0] right_res;
    logic             right_carry;

    // A left shift is a right shift of the bit-reversed word.
    always_comb begin
        src  = (kind == SHK_LSL) ? flip(value) : value;
        case (kind)
            SHK_ASR: fill = {WIDTH{value[WIDTH-1]}};
            SHK_ROR: fill = value;
            default: fill = '0;
        endcase
    end

    // Guard bit below the word collects the last bit shifted out.
    assign stage[0] = {fill, src, 1'b0};

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        assign stage[s+1] = amount[s] ? (stage[s] >> (1 << s)) : stage[s];
    end

    assign right_res   = stage[SHW][WIDTH:1];
    assign right_carry = stage[SHW][0];

    always_comb begin
        result    = value;
        carry_out = carry_in;
        case (kind)
            SHK_LSL, SHK_LSR, SHK_ASR, SHK_ROR: begin
                if (amount != '0) begin
                    result    = (kind == SHK_LSL) ? flip(right_res) : right_res;
                    carry_out = right_carry;
                end
            end
            SHK_RRX: begin
                result    = {carry_in, value[WIDTH-1:1]};
                carry_out = value[0];
            end
            default: begin
                result    = value;
                carry_out = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/flex_operand_gen.sv
module flex_operand_gen
    import opgen_pkg::*;
(
    input  logic               use_imm,
    input  logic [BYTE_W-1:0]  imm_byte,
    input  logic [1:0]         imm_form,
    input  logic [SHAMT_W-1:0] imm_offset,
    input  logic [WORD_W-1:0]  reg_val,
    input  logic [2:0]         sh_kind,
    input  logic [SHAMT_W-1:0] sh_amount,
    input  logic               carry_in,
    output logic [WORD_W-1:0]  operand,
    output logic               carry_out
);
    logic [WORD_W-1:0] imm_word;
    operand_t          shifted;
    operand_t          chosen;

    opgen_imm_expand #(.WIDTH(WORD_W), .BW(BYTE_W)) u_imm (
        .value  (imm_byte),
        .form   (imm_form_e'(imm_form)),
        .offset (imm_offset),
        .word   (imm_word)
    );

    opgen_shifter #(.WIDTH(WORD_W)) u_shift (
        .value     (reg_val),
        .kind      (shift_kind_e'(sh_kind)),
        .amount    (sh_amount),
        .carry_in  (carry_in),
        .result    (shifted.data),
        .carry_out (shifted.carry)
    );

    always_comb begin
        if (use_imm) begin
            chosen.data  = imm_word;
            chosen.carry = carry_in;
        end else begin
            chosen = shifted;
        end
    end

    assign operand   = chosen.data;
    assign carry_out = chosen.carry;

endmodule

// File: rtl/flex_operand_gen_chk.sv
module flex_operand_gen_chk
    import opgen_pkg::*;
(
    input logic               use_imm,
    input logic [BYTE_W-1:0]  imm_byte,
    input logic [1:0]         imm_form,
    input logic [SHAMT_W-1:0] imm_offset,
    input logic [WORD_W-1:0]  reg_val,
    input logic [2:0]         sh_kind,
    input logic [SHAMT_W-1:0] sh_amount,
    input logic               carry_in,
    input logic [WORD_W-1:0]  operand,
    input logic               carry_out
);
    always_comb begin
        if (use_imm) begin
            AST_IMM_CARRY_PASS: assert (carry_out == carry_in) else $error("imm carry");  // R4
            if (imm_form == 2'd1) begin
                AST_EVEN_LANES: assert (operand[31:24] == 8'h00 && operand[15:8] == 8'h00
                                        && operand[7:0] == imm_byte) else $error("even lanes");  // R2
            end
            if (imm_form == 2'd3) begin
                AST_ALL_LANES: assert (operand[31:24] == imm_byte && operand[7:0] == imm_byte)
                               else $error("all lanes");  // R3
            end
        end else begin
            if (sh_kind < 3'd4 && sh_amount == '0) begin
                AST_ZERO_AMOUNT: assert (operand == reg_val && carry_out == carry_in)
                                 else $error("zero amount");  // R9
            end
            if (sh_kind == 3'd0 && sh_amount != '0) begin
                AST_LSL_LOW_ZERO: assert (operand[0] == 1'b0) else $error("lsl low");  // R5
            end
            if (sh_kind == 3'd1 && sh_amount != '0) begin
                AST_LSR_TOP_ZERO: assert (operand[31] == 1'b0) else $error("lsr top");  // R6
            end
            if (sh_kind == 3'd2 && sh_amount != '0) begin
                AST_ASR_SIGN: assert (operand[31] == reg_val[31]) else $error("asr sign");  // R7
            end
            if (sh_kind == 3'd3 && sh_amount != '0) begin
                AST_ROR_CARRY: assert (carry_out == operand[31]) else $error("ror carry");  // R8
            end
            if (sh_kind == 3'd4) begin
                AST_RRX_LINK: assert (operand[31] == carry_in && carry_out == reg_val[0])
                              else $error("rrx");  // R10
            end
            if (sh_kind > 3'd4) begin
                AST_RSV_PASS: assert (operand == reg_val && carry_out == carry_in)
                              else $error("reserved");  // R11
            end
        end
    end
endmodule

bind flex_operand_gen flex_operand_gen_chk u_chk (.*);

// File: tb/flex_operand_gen_test.sv
module flex_operand_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        use_imm = 1'b0;
    logic [7:0]  imm_byte = '0;
    logic [1:0]  imm_form = '0;
    logic [4:0]  imm_offset = '0;
    logic [31:0] reg_val = '0;
    logic [2:0]  sh_kind = '0;
    logic [4:0]  sh_amount = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    flex_operand_gen uut (
        .use_imm(use_imm), .imm_byte(imm_byte), .imm_form(imm_form),
        .imm_offset(imm_offset), .reg_val(reg_val), .sh_kind(sh_kind),
        .sh_amount(sh_amount), .carry_in(carry_in),
        .operand(operand), .carry_out(carry_out)
    );

    function automatic string tag_of();
        if (use_imm) begin
            case (imm_form)
                2'd0: return "R1";
                2'd1: return "R2";
                default: return "R3";
            endcase
        end
        if (sh_kind < 3'd4 && sh_amount == 5'd0) return "R9";
        case (sh_kind)
            3'd0: return "R5";
            3'd1: return "R6";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic model(output logic [31:0] e, output logic ec);
        int n;
        n = int'(sh_amount);
        ec = carry_in;
        if (use_imm) begin
            case (imm_form)
                2'd0: e = 32'(longint'(imm_byte) << imm_offset);
                2'd1: e = {8'h00, imm_byte, 8'h00, imm_byte};
                2'd2: e = {imm_byte, 8'h00, imm_byte, 8'h00};
                default: e = {4{imm_byte}};
            endcase
        end else if (sh_kind == 3'd4) begin
            e  = {carry_in, reg_val[31:1]};
            ec = reg_val[0];
        end else if (sh_kind > 3'd4 || n == 0) begin
            e = reg_val;
        end else begin
            case (sh_kind)
                3'd0: begin e = reg_val << n; ec = reg_val[32-n]; end
                3'd1: begin e = reg_val >> n; ec = reg_val[n-1]; end
                3'd2: begin e = 32'($signed(reg_val) >>> n); ec = reg_val[n-1]; end
                default: begin e = (reg_val >> n) | (reg_val << (32 - n)); ec = reg_val[n-1]; end
            endcase
        end
    endtask

    task automatic compare(input string tag);
        logic [31:0] e;
        logic        ec;
        model(e, ec);
        checks++;
        if (operand !== e || carry_out !== ec) begin
            errors++;
            $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                     tag, operand, carry_out, e, ec);
        end
    endtask

    task automatic apply(input logic ui, input logic [7:0] b, input logic [1:0] f,
                         input logic [4:0] off, input logic [31:0] r, input logic [2:0] k,
                         input logic [4:0] a, input logic ci);
        @(negedge clk);
        use_imm = ui; imm_byte = b; imm_form = f; imm_offset = off;
        reg_val = r; sh_kind = k; sh_amount = a; carry_in = ci;
        @(posedge clk);
        compare(tag_of());
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // reset state: all-zero inputs give zero outputs (R9)
        compare("R9");
        rst = 1'b0;

        // R1 placed byte, including high offsets that drop bits
        apply(1, 8'hAB, 2'd0, 5'd0,  32'hFFFF_FFFF, 3'd0, 5'd7, 1'b1);
        apply(1, 8'hAB, 2'd0, 5'd12, 32'h0, 3'd0, 5'd0, 1'b0);
        apply(1, 8'hAB, 2'd0, 5'd28, 32'h0, 3'd0, 5'd0, 1'b0);
        apply(1, 8'hFF, 2'd0, 5'd31, 32'h0, 3'd0, 5'd0, 1'b1);
        // R2 / R3 replication, offset must be ignored
        apply(1, 8'h5C, 2'd1, 5'd9,  32'h0, 3'd0, 5'd0, 1'b0);
        apply(1, 8'h5C, 2'd2, 5'd17, 32'h0, 3'd0, 5'd0, 1'b1);
        apply(1, 8'h5C, 2'd3, 5'd31, 32'h0, 3'd0, 5'd0, 1'b0);
        // R4 register inputs do not leak into immediate mode
        apply(1, 8'h12, 2'd0, 5'd4, 32'hDEAD_BEEF, 3'd4, 5'd3, 1'b1);
        // R5 LSL boundaries
        apply(0, 8'h0, 2'd0, 5'd0, 32'h8000_0001, 3'd0, 5'd1,  1'b0);
        apply(0, 8'h0, 2'd0, 5'd0, 32'h0000_0003, 3'd0, 5'd31, 1'b0);
        // R6 LSR
        apply(0, 8'h0, 2'd0, 5'd0, 32'h8000_0001, 3'd1, 5'd1,  1'b0);
        apply(0, 8'h0, 2'd0, 5'd0, 32'hC000_0000, 3'd1, 5'd31, 1'b0);
        // R7 ASR, negative and positive
        apply(0, 8'h0, 2'd0, 5'd0, 32'h8000_0000, 3'd2, 5'd31, 1'b0);
        apply(0, 8'h0, 2'd0, 5'd0, 32'h4000_0010, 3'd2, 5'd5,  1'b1);
        // R8 ROR
        apply(0, 8'h0, 2'd0, 5'd0, 32'h1234_8001, 3'd3, 5'd16, 1'b0);
        apply(0, 8'h0, 2'd0, 5'd0, 32'h0000_0001, 3'd3, 5'd1,  1'b0);
        // R9 zero amount on each kind
        for (int k = 0; k < 4; k++) begin
            apply(0, 8'h0, 2'd0, 5'd0, 32'hA5A5_0F0F, 3'(k), 5'd0, 1'b1);
        end
        // R10 rotate through carry, amount ignored
        apply(0, 8'h0, 2'd0, 5'd0, 32'h0000_0003, 3'd4, 5'd0,  1'b1);
        apply(0, 8'h0, 2'd0, 5'd0, 32'hFFFF_FFFE, 3'd4, 5'd19, 1'b0);
        // R11 unused codes
        for (int k = 5; k < 8; k++) begin
            apply(0, 8'h0, 2'd0, 5'd0, 32'h1357_9BDF, 3'(k), 5'd9, 1'b1);
        end
        // R12 output follows input change with no clock edge
        @(negedge clk);
        reg_val = 32'h0F00_0000; sh_kind = 3'd1; sh_amount = 5'd24; use_imm = 1'b0;
        #1 compare("R12");
        sh_kind = 3'd0; sh_amount = 5'd4;
        #1 compare("R12");

        // random patterns
        for (int i = 0; i < 3000; i++) begin
            apply(1'($urandom), 8'($urandom), 2'($urandom), 5'($urandom),
                  $urandom, 3'($urandom), 5'($urandom), 1'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule